// File: doc/BRIEF.md
# ATA Task-File Register and Status Unit

This block is the device-side register file of a parallel ATA disk port. A host talks to it through a simple byte-register bus with eight offsets. It keeps the parameter registers, the device-select register and the status and error registers. A 16-bit data port carries the word stream of a programmed-I/O read-out. A small command sequencer handles three cases. IDENTIFY streams a fixed number of words from a back-end word source. FLUSH CACHE holds the unit busy until the back end reports completion. Every other opcode, and every command that fails validation, is aborted.

The interrupt line is raised when a command completes and is cleared as a side effect of reading the status register. The media back end is outside the block. It appears as a level flush request with a done pulse, and as a word source addressed by the current word index.

Top module: `ata_taskfile_unit`

## Requirements
- R1: After reset, status reads 0x40 (only DRDY set), the error register reads 0x00, the interrupt is low and the flush request is low.
- R2: Offsets 2 (sector count), 3, 4 and 5 (LBA bytes) and 6 (device) read back the last byte written to them. A write to offset 1 goes to the feature register, and a read of offset 1 returns the error register, which that write leaves unchanged.
- R3: After command 0xEC is written to offset 7 with device bit 0x10 clear, status reads 0x48 (DRDY and DRQ) before each of WORDS reads of offset 0. Read k returns the back-end word at index k. After the last read, status reads 0x40.
- R4: The start of an IDENTIFY read-out raises the interrupt, and a read of offset 7 (status) clears it.
- R5: Command 0xE7 makes status read 0xC0 (BSY and DRDY) and holds the flush request high until the back end pulses done. Status then reads 0x40 and the interrupt rises.
- R6: An unrecognised opcode completes at once with status 0x41 (DRDY and ERR), error register 0x04 (ABRT) and the interrupt raised.
- R7: A command issued with device bit 0x10 set fails with status 0x41 and error 0x04. A command that is accepted clears any earlier ERR and error value, and after it the device register still reads with bit 0x10 clear.
- R8: While BSY is set, writes to offsets 0 through 6 are ignored.
- R9: A command write while BSY is set aborts the flush. BSY and the flush request drop, status reads 0x41, error reads 0x04 and the interrupt rises. A later done pulse changes nothing.
- R10: While the interrupt-disable input is high, command completions do not raise the interrupt, and nothing stays pending once the input is released.
- R11: A read of offset 0 while DRQ is clear returns 0 and leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data; the upper byte is nonzero only on the data port |
| irq | output | 1 | Interrupt request to the host |
| intr_disable | input | 1 | Suppresses interrupt generation |
| flush_req | output | 1 | Level request to the back end for a cache flush |
| flush_done | input | 1 | One-cycle completion pulse from the back end |
| word_index | output | IDX_W | Index of the word currently presented |
| word_in | input | WORD_W | Back-end word for word_index |

## Verification
The bench builds the unit with its default parameters: a 256-word IDENTIFY read-out and 16-bit words. With these values the full read-out runs at its real length. The DRQ drop is seen on the last index, where the 8-bit counter also wraps. The word source is a function of the index, so a reordered or skipped word shows up as a mismatch. Back-end timing is controlled directly by the bench, which makes the busy window long enough to try ignored writes and an aborting command inside it.

// File: rtl/ata_taskfile_unit.sv
module ata_taskfile_unit #(
  parameter int WORDS  = 256,
  parameter int WORD_W = 16,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              irq,
  input  logic              intr_disable,
  output logic              flush_req,
  input  logic              flush_done,
  output logic [IDX_W-1:0]  word_index,
  input  logic [WORD_W-1:0] word_in
);

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] ABORTED  = 8'h04;
  localparam logic [2:0] A_DATA = 3'd0, A_ERR = 3'd1, A_CMD = 3'd7;

  logic [7:0] feat_q, count_q, lba0_q, lba1_q, lba2_q, dev_q, err_q;
  logic       bsy_q, drq_q, fail_q, pend_q;
  logic [IDX_W-1:0] idx_q;

  logic wr, rd, cmd_wr, reg_wr, data_rd, stat_rd, last_word, flush_end;
  logic starts_flush, done_evt;
  logic [7:0] status;

  assign wr        = host_req & host_we;
  assign rd        = host_req & ~host_we;
  assign cmd_wr    = wr & (host_addr == A_CMD);
  assign reg_wr    = wr & (host_addr != A_CMD) & ~bsy_q;
  assign data_rd   = rd & (host_addr == A_DATA) & drq_q;
  assign stat_rd   = rd & (host_addr == A_CMD);
  assign last_word = idx_q == IDX_W'(WORDS - 1);
  assign flush_end = bsy_q & flush_done & ~cmd_wr;
  assign starts_flush = cmd_wr & ~bsy_q & ~dev_q[4] & (host_wdata == OP_FLUSH);
  assign done_evt  = (cmd_wr & ~starts_flush) | flush_end;

  assign status     = {bsy_q, 1'b1, 1'b0, 1'b0, drq_q, 2'b00, fail_q};
  assign irq        = pend_q & ~intr_disable;
  assign flush_req  = bsy_q;
  assign word_index = idx_q;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_DATA:  host_rdata = drq_q ? word_in : '0;
      A_ERR:   host_rdata[7:0] = err_q;
      3'd2:    host_rdata[7:0] = count_q;
      3'd3:    host_rdata[7:0] = lba0_q;
      3'd4:    host_rdata[7:0] = lba1_q;
      3'd5:    host_rdata[7:0] = lba2_q;
      3'd6:    host_rdata[7:0] = dev_q;
      default: host_rdata[7:0] = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_q <= '0; count_q <= '0; lba0_q <= '0; lba1_q <= '0; lba2_q <= '0;
      dev_q <= '0; err_q <= '0; bsy_q <= 1'b0; drq_q <= 1'b0; fail_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (reg_wr) begin
        case (host_addr)
          3'd1: feat_q  <= host_wdata;
          3'd2: count_q <= host_wdata;
          3'd3: lba0_q  <= host_wdata;
          3'd4: lba1_q  <= host_wdata;
          3'd5: lba2_q  <= host_wdata;
          3'd6: dev_q   <= host_wdata;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        drq_q <= 1'b0;
        bsy_q <= 1'b0;
        if (bsy_q || dev_q[4]) begin
          fail_q <= 1'b1;
          err_q  <= ABORTED;
        end else begin
          case (host_wdata)
            OP_IDENT: begin
              drq_q <= 1'b1; idx_q <= '0; fail_q <= 1'b0; err_q <= '0;
            end
            OP_FLUSH: begin
              bsy_q <= 1'b1; fail_q <= 1'b0; err_q <= '0;
            end
            default: begin
              fail_q <= 1'b1; err_q <= ABORTED;
            end
          endcase
        end
      end else if (flush_end) begin
        bsy_q <= 1'b0;
      end else if (data_rd) begin
        idx_q <= idx_q + 1'b1;
        if (last_word) drq_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        pend_q <= 1'b0;
    else if (done_evt && !intr_disable) pend_q <= 1'b1;
    else if (stat_rd)                  pend_q <= 1'b0;
  end

  assert_bsy_drq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy_q && drq_q));

  assert_bsy_from_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_q) |-> $past(cmd_wr));

  assert_drq_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq_q) |-> $past(cmd_wr) || $past(data_rd && last_word));

  assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_evt) |=> !irq);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !$past(intr_disable));

  assert_err_abrt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> err_q == ABORTED);

  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bsy_q) && bsy_q |-> $stable(count_q) && $stable(dev_q));

endmodule

// File: tb/test_ata_taskfile_unit.sv
`timescale 1ns/1ps
module test_ata_taskfile_unit;
  localparam int WORDS = 256;
  localparam int IDX_W = 8;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0, intr_disable = 0, flush_done = 0;
  logic [2:0]  host_addr = 0;
  logic [7:0]  host_wdata = 0;
  logic [15:0] host_rdata, word_in;
  logic irq, flush_req;
  logic [IDX_W-1:0] word_index;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign word_in = {~word_index, word_index};

  ata_taskfile_unit i_ata_taskfile_unit (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .intr_disable(intr_disable), .flush_req(flush_req),
    .flush_done(flush_done), .word_index(word_index), .word_in(word_in));

  // {offset, write byte, expected read-back}
  localparam logic [18:0] VEC [6] = '{
    {3'd2, 8'h12, 8'h12}, {3'd3, 8'h34, 8'h34}, {3'd4, 8'h56, 8'h56},
    {3'd5, 8'h78, 8'h78}, {3'd6, 8'h40, 8'h40}, {3'd1, 8'hAA, 8'h00}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_req = 0; host_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    #2 v = host_rdata;
    @(posedge clk); #1;
    host_req = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); flush_done = 1;
    @(negedge clk); flush_done = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int bad;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(3'd7, v); check("R1 status", v, 16'h0040);
    rd(3'd1, v); check("R1 error", v, 16'h0000);
    check("R1 irq/flush", {14'd0, irq, flush_req}, 16'h0000);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      check("R2 readback", v, {8'h00, VEC[i][7:0]});
    end

    wr(3'd7, 8'h50);
    @(negedge clk); check("R6 irq", {15'd0, irq}, 16'h1);
    rd(3'd7, v); check("R6 status", v, 16'h0041);
    rd(3'd1, v); check("R6 error", v, 16'h0004);
    check("R4 cleared by status read", {15'd0, irq}, 16'h0);

    wr(3'd7, 8'hEC);
    @(negedge clk); check("R4 irq on identify", {15'd0, irq}, 16'h1);
    rd(3'd1, v); check("R7 error cleared", v, 16'h0000);
    rd(3'd6, v); check("R7 device bit clear", v & 16'h0010, 16'h0000);
    bad = 0;
    for (int k = 0; k < WORDS; k++) begin
      rd(3'd7, v); if (v !== 16'h0048) bad++;
      rd(3'd0, v); if (v !== {~k[7:0], k[7:0]}) bad++;
    end
    check("R3 words and status", bad[15:0], 16'h0);
    check("R4 irq cleared", {15'd0, irq}, 16'h0);
    rd(3'd7, v); check("R3 final status", v, 16'h0040);

    rd(3'd0, v); check("R11 idle data read", v, 16'h0000);
    rd(3'd7, v); check("R11 status unchanged", v, 16'h0040);

    wr(3'd7, 8'hE7);
    rd(3'd7, v); check("R5 busy status", v, 16'h00C0);
    check("R5 flush_req", {15'd0, flush_req}, 16'h1);
    wr(3'd2, 8'h99);
    wr(3'd6, 8'h50);
    repeat (5) @(posedge clk);
    rd(3'd7, v); check("R5 still busy", v, 16'h00C0);
    pulse_done();
    @(negedge clk); check("R5 irq on done", {14'd0, irq, flush_req}, 16'h2);
    rd(3'd7, v); check("R5 done status", v, 16'h0040);
    rd(3'd2, v); check("R8 count kept", v, 16'h0012);
    rd(3'd6, v); check("R8 device kept", v, 16'h0040);

    wr(3'd7, 8'hE7);
    wr(3'd7, 8'h00);
    @(negedge clk); check("R9 abort irq/flush", {14'd0, irq, flush_req}, 16'h2);
    rd(3'd7, v); check("R9 status", v, 16'h0041);
    rd(3'd1, v); check("R9 error", v, 16'h0004);
    pulse_done();
    @(negedge clk); check("R9 late done irq", {15'd0, irq}, 16'h0);
    rd(3'd7, v); check("R9 late done status", v, 16'h0041);

    wr(3'd6, 8'h50);
    wr(3'd7, 8'hEC);
    rd(3'd7, v); check("R7 device 1 status", v, 16'h0041);
    rd(3'd1, v); check("R7 device 1 error", v, 16'h0004);

    wr(3'd6, 8'h40);
    intr_disable = 1;
    wr(3'd7, 8'h50);
    @(negedge clk); check("R10 irq masked", {15'd0, irq}, 16'h0);
    intr_disable = 0;
    @(negedge clk); check("R10 nothing pending", {15'd0, irq}, 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule